// File: doc/BRIEF.md
# Periodic Interrupt Timer with Compare

This block is a 32-bit down-counter that raises a level interrupt at a point in each count period chosen by software. Software reaches it through a single-cycle register port with one shared word address. The port holds a control word, a status flag, a load value, a compare value and a read-only view of the live count. Count steps come from one of two tick-enable inputs, both in the system clock domain. Two source codes pick the main tick, one code picks the slow tick, and one code disables ticking. A 12-bit prescaler then divides the selected tick rate.

When the counter expires, it either reloads from the load register or wraps to all ones and keeps running. A compare match sets a sticky flag. Software clears the flag by writing 1 to it. The interrupt line is the flag gated by both the compare-interrupt enable and the run enable. A control write with its reset bit set performs a partial reset. This partial reset clears the run state and the data registers, and it keeps the configuration fields that are written along with it.

Top module: `cmp_period_timer`

## Requirements
- R1: Word offsets select the registers: 0 is control, 1 is status, 2 is load, 3 is compare and 4 is the live count. The count register is read-only. Offsets 5 to 7 read as zero. Writes to offsets 4 to 7 change nothing.
- R2: A control write stores bits 25:0 and forces bits 31:26 to zero. The fields are: bit0 run, bit1 restart mode, bit2 compare-interrupt enable, bit3 reload select, bits 15:4 prescaler, bit16 soft reset, bit17 overwrite-on-load, bits 21:18 four low-power enables (stored only), and bits 25:24 tick source.
- R3: Tick source 00 gives no steps. Sources 01 and 10 use `tick_main` and source 11 uses `tick_slow`. The counter steps once for every prescaler+1 selected ticks. A control write clears the prescaler phase.
- R4: While running, each step decrements the count. A step at zero loads the load value if reload select is 1, and loads 0xFFFFFFFF otherwise.
- R5: A control write with run=1 and restart mode=1 sets the count in that cycle. The count becomes the load value if the written reload select is 1, and 0xFFFFFFFF otherwise. With run=0 the count holds. A write with run=1 and restart mode=0 continues from the current count.
- R6: A load write while overwrite-on-load is 1 copies the value into the count at once. Otherwise the count keeps running and picks up the new value at its next reload.
- R7: With the compare-interrupt enable set, status bit0 is set by a step that takes the count from compare+1 to a nonzero compare value. When the compare value is zero, the flag is set by the expiry step instead.
- R8: Writing status with bit0=1 clears the flag, and writing bit0=0 leaves it unchanged. A flag set in the same cycle as a clear wins.
- R9: `irq` is high exactly while the flag, the compare-interrupt enable and run are all 1.
- R10: Synchronous reset gives control 0, status 0, compare 0, count 0 and load 0xFFFFFFFF.
- R11: A control write with bit16=1 sets load to 0xFFFFFFFF and sets compare, count and status to 0. Run, restart mode, the four low-power enables and bit16 then read 0, and the other fields take the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 3 | Word offset for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tick_main | input | 1 | Main tick enable, one cycle wide |
| tick_slow | input | 1 | Slow tick enable, one cycle wide |
| irq | output | 1 | Level interrupt |

## Verification
The properties assume that the tick inputs are single-cycle enables sampled on `clk`. They also assume that a step can only be disturbed through a bus write. For this reason the counting and flag properties are qualified on `bus_wr` being low, or on both tick inputs being low for the acknowledge case. The stimulus keeps the bus idle while ticks are pulsed, except in the one deliberate cycle that tests a set against a clear. Each read is sampled at the falling edge after the address has settled.

// File: rtl/cpt_pkg.sv
`timescale 1ns/1ps
package cpt_pkg;
    localparam int DW      = 32;
    localparam int AW      = 3;
    localparam int PS_W    = 12;
    localparam int KEEP_W  = 26;
    localparam logic [DW-1:0] ALL_ONES  = '1;
    localparam logic [DW-1:0] CTRL_MASK = {{(DW-KEEP_W){1'b0}}, {KEEP_W{1'b1}}};

    typedef enum logic [AW-1:0] {
        OFS_CTRL  = 3'd0,
        OFS_STAT  = 3'd1,
        OFS_LOAD  = 3'd2,
        OFS_CMP   = 3'd3,
        OFS_COUNT = 3'd4
    } ofs_e;

    typedef enum logic [1:0] {
        SRC_NONE   = 2'b00,
        SRC_MAIN_A = 2'b01,
        SRC_MAIN_B = 2'b10,
        SRC_SLOW   = 2'b11
    } src_e;

    typedef struct packed {
        logic [5:0]      zero_hi;
        src_e            src;
        logic [1:0]      zero_mid;
        logic            stop_en;
        logic            doze_en;
        logic            wait_en;
        logic            dbg_en;
        logic            ovw;
        logic            swr;
        logic [PS_W-1:0] presc;
        logic            reload;
        logic            cmp_ie;
        logic            restart_md;
        logic            run;
    } ctrl_t;

    // Value stored by a control write; a soft reset drops the run state.
    function automatic ctrl_t ctrl_from_write(input logic [DW-1:0] w);
        ctrl_t c;
        c = ctrl_t'(w & CTRL_MASK);
        if (c.swr) begin
            c.run        = 1'b0;
            c.restart_md = 1'b0;
            c.dbg_en     = 1'b0;
            c.wait_en    = 1'b0;
            c.doze_en    = 1'b0;
            c.stop_en    = 1'b0;
        end
        c.swr = 1'b0;
        return c;
    endfunction

    function automatic logic [DW-1:0] start_value(input ctrl_t c, input logic [DW-1:0] ld);
        return c.reload ? ld : ALL_ONES;
    endfunction
endpackage

// File: rtl/cpt_prescale.sv
`timescale 1ns/1ps
module cpt_prescale
    import cpt_pkg::*;
#(
    parameter int PW = PS_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  src_e          src,
    input  logic [PW-1:0] div,
    input  logic          clr,
    input  logic          tick_main,
    input  logic          tick_slow,
    output logic          step_o
);
    logic          src_tick;
    logic          at_div;
    logic [PW-1:0] phase_q;

    always_comb begin
        case (src)
            SRC_MAIN_A, SRC_MAIN_B: src_tick = tick_main;
            SRC_SLOW:               src_tick = tick_slow;
            default:                src_tick = 1'b0;
        endcase
    end

    assign at_div = (phase_q == div);
    assign step_o = run && !clr && src_tick && at_div;

    always_ff @(posedge clk) begin
        if (rst || clr || !run) begin
            phase_q <= '0;
        end else if (src_tick) begin
            phase_q <= at_div ? '0 : phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/cpt_counter.sv
`timescale 1ns/1ps
module cpt_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic         clear,
    input  logic         restart,
    input  logic [W-1:0] restart_val,
    input  logic         force_ld,
    input  logic [W-1:0] force_val,
    input  logic [W-1:0] wrap_val,
    input  logic [W-1:0] cmp_val,
    output logic [W-1:0] cnt_q,
    output logic         expire_o,
    output logic         hit_o
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic         at_zero;
    logic         bus_owns;
    logic [W-1:0] dec;

    assign at_zero  = (cnt_q == '0);
    assign bus_owns = clear || restart || force_ld;
    assign dec      = cnt_q - ONE;
    assign expire_o = step && !bus_owns && at_zero;
    assign hit_o    = step && !bus_owns && !at_zero && (dec == cmp_val) && (cmp_val != '0);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= restart_val;
        end else if (force_ld) begin
            cnt_q <= force_val;
        end else if (step) begin
            cnt_q <= at_zero ? wrap_val : dec;
        end
    end
endmodule

// File: rtl/cpt_regs.sv
`timescale 1ns/1ps
module cpt_regs
    import cpt_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] cnt_q,
    input  logic          flag_set,
    output ctrl_t         ctrl_q,
    output logic [DW-1:0] load_q,
    output logic [DW-1:0] cmp_q,
    output logic          flag_q,
    output logic [DW-1:0] bus_rdata,
    output logic          ctrl_wr,
    output logic          swr_evt,
    output logic          restart_evt,
    output logic [DW-1:0] restart_val,
    output logic          force_evt
);
    ctrl_t ctrl_new;
    logic  sel_stat, sel_load, sel_cmp;

    assign ctrl_new    = ctrl_from_write(bus_wdata);
    assign ctrl_wr     = bus_wr && (bus_addr == OFS_CTRL);
    assign sel_stat    = bus_wr && (bus_addr == OFS_STAT);
    assign sel_load    = bus_wr && (bus_addr == OFS_LOAD);
    assign sel_cmp     = bus_wr && (bus_addr == OFS_CMP);
    assign swr_evt     = ctrl_wr && bus_wdata[16];
    assign restart_evt = ctrl_wr && ctrl_new.run && ctrl_new.restart_md;
    assign restart_val = start_value(ctrl_new, load_q);
    assign force_evt   = sel_load && ctrl_q.ovw;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            load_q <= ALL_ONES;
            cmp_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            if (ctrl_wr) ctrl_q <= ctrl_new;
            if (swr_evt) begin
                load_q <= ALL_ONES;
                cmp_q  <= '0;
            end else begin
                if (sel_load) load_q <= bus_wdata;
                if (sel_cmp)  cmp_q  <= bus_wdata;
            end
            if (swr_evt)                      flag_q <= 1'b0;
            else if (flag_set)                flag_q <= 1'b1;
            else if (sel_stat && bus_wdata[0]) flag_q <= 1'b0;
        end
    end

    always_comb begin
        case (bus_addr)
            OFS_CTRL:  bus_rdata = ctrl_q;
            OFS_STAT:  bus_rdata = {{(DW-1){1'b0}}, flag_q};
            OFS_LOAD:  bus_rdata = load_q;
            OFS_CMP:   bus_rdata = cmp_q;
            OFS_COUNT: bus_rdata = cnt_q;
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/cmp_period_timer.sv
`timescale 1ns/1ps
module cmp_period_timer
    import cpt_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          tick_main,
    input  logic          tick_slow,
    output logic          irq
);
    ctrl_t         ctrl_q;
    logic [DW-1:0] load_q, cmp_q, cnt_q, restart_val, wrap_val;
    logic          flag_q, flag_set, ctrl_wr, swr_evt, restart_evt, force_evt;
    logic          tick_w, expire, hit;

    cpt_regs regs_i (
        .clk         (clk),
        .rst         (rst),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .cnt_q       (cnt_q),
        .flag_set    (flag_set),
        .ctrl_q      (ctrl_q),
        .load_q      (load_q),
        .cmp_q       (cmp_q),
        .flag_q      (flag_q),
        .bus_rdata   (bus_rdata),
        .ctrl_wr     (ctrl_wr),
        .swr_evt     (swr_evt),
        .restart_evt (restart_evt),
        .restart_val (restart_val),
        .force_evt   (force_evt)
    );

    cpt_prescale #(.PW(PS_W)) presc_i (
        .clk       (clk),
        .rst       (rst),
        .run       (ctrl_q.run),
        .src       (ctrl_q.src),
        .div       (ctrl_q.presc),
        .clr       (ctrl_wr),
        .tick_main (tick_main),
        .tick_slow (tick_slow),
        .step_o    (tick_w)
    );

    assign wrap_val = start_value(ctrl_q, load_q);

    cpt_counter #(.W(DW)) cnt_i (
        .clk         (clk),
        .rst         (rst),
        .step        (tick_w),
        .clear       (swr_evt),
        .restart     (restart_evt),
        .restart_val (restart_val),
        .force_ld    (force_evt),
        .force_val   (bus_wdata),
        .wrap_val    (wrap_val),
        .cmp_val     (cmp_q),
        .cnt_q       (cnt_q),
        .expire_o    (expire),
        .hit_o       (hit)
    );

    assign flag_set = ctrl_q.cmp_ie && (hit || (expire && (cmp_q == '0)));
    assign irq      = flag_q && ctrl_q.cmp_ie && ctrl_q.run;
endmodule

// File: rtl/cpt_checker.sv
`timescale 1ns/1ps
module cpt_checker
    import cpt_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          bus_wr,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_rdata,
    input logic          ack_bit,
    input logic          swr_bit,
    input logic          tick_main,
    input logic          tick_slow,
    input logic          tick_fire,
    input logic          ctrl_run,
    input logic          ctrl_reload,
    input logic [DW-1:0] cnt_q,
    input logic [DW-1:0] load_q,
    input logic          flag_q,
    input logic          irq
);
    AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (rst) (bus_addr > 3'd4) |-> (bus_rdata == '0)); // R1
    AST_CNT_DECREMENT: assert property (@(posedge clk) disable iff (rst) (tick_fire && !bus_wr && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 32'd1)); // R4
    AST_CNT_FREE_WRAP: assert property (@(posedge clk) disable iff (rst) (tick_fire && !bus_wr && cnt_q == '0 && !ctrl_reload) |=> (cnt_q == ALL_ONES)); // R4
    AST_CNT_HALTED: assert property (@(posedge clk) disable iff (rst) (!ctrl_run && !bus_wr) |=> $stable(cnt_q)); // R5
    AST_FLAG_ACK: assert property (@(posedge clk) disable iff (rst) (bus_wr && bus_addr == 3'd1 && ack_bit && !tick_main && !tick_slow) |=> !flag_q); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst) (flag_q && !bus_wr) |=> flag_q); // R8
    AST_IRQ_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst) !ctrl_run |-> !irq); // R9
    AST_SOFT_RESET: assert property (@(posedge clk) disable iff (rst) (bus_wr && bus_addr == 3'd0 && swr_bit) |=> (cnt_q == '0 && load_q == ALL_ONES && !flag_q && !ctrl_run)); // R11
endmodule

bind cmp_period_timer cpt_checker chk_i (
    .clk         (clk),
    .rst         (rst),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_rdata   (bus_rdata),
    .ack_bit     (bus_wdata[0]),
    .swr_bit     (bus_wdata[16]),
    .tick_main   (tick_main),
    .tick_slow   (tick_slow),
    .tick_fire   (tick_w),
    .ctrl_run    (ctrl_q.run),
    .ctrl_reload (ctrl_q.reload),
    .cnt_q       (cnt_q),
    .load_q      (load_q),
    .flag_q      (flag_q),
    .irq         (irq)
);

// File: tb/cmp_period_timer_tb_top.sv
`timescale 1ns/1ps
module cmp_period_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_main = 1'b0;
    logic        tick_slow = 1'b0;
    logic        irq;
    int          n_run = 0;
    int          n_fail = 0;

    always #10 clk = ~clk;

    cmp_period_timer dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_main(tick_main), .tick_slow(tick_slow), .irq(irq)
    );

    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TM = 2'd2, OP_TS = 2'd3;
    localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_LOAD = 3'd2, A_CMP = 3'd3, A_CNT = 3'd4;

    typedef struct packed {
        logic [1:0]  op;
        logic [2:0]  ofs;
        logic [31:0] val;
        logic [31:0] exp;
        logic        exp_irq;
        logic [3:0]  req;
    } vec_t;

    function automatic vec_t mk(input logic [1:0] op, input logic [2:0] ofs, input logic [31:0] val,
                                input logic [31:0] exp, input logic ex_irq, input logic [3:0] req);
        mk = {op, ofs, val, exp, ex_irq, req};
    endfunction

    localparam int NV = 59;
    localparam vec_t VECS [NV] = '{
        mk(OP_WR, A_LOAD, 32'd5, 32'd0, 1'b0, 4'd0),
        mk(OP_RD, A_LOAD, 32'd0, 32'd5, 1'b0, 4'd1),            // R1 load readback
        mk(OP_WR, A_CTRL, 32'h0100000B, 32'd0, 1'b0, 4'd0),
        mk(OP_RD, A_CNT,  32'd0, 32'd5, 1'b0, 4'd5),            // R5 restart from load
        mk(OP_RD, A_CTRL, 32'd0, 32'h0100000B, 1'b0, 4'd2),     // R2 readback
        mk(OP_TM, A_CTRL, 32'd3, 32'd0, 1'b0, 4'd0),
        mk(OP_RD, A_CNT,  32'd0, 32'd2, 1'b0, 4'd4),            // R4 decrement
        mk(OP_TM, A_CTRL, 32'd3, 32'd0, 1'b0, 4'd0),
        mk(OP_RD, A_CNT,  32'd0, 32'd5, 1'b0, 4'd4),            // R4 reload at expiry
        mk(OP_WR, A_CMP,  32'd3, 32'd0, 1'b0, 4'd0),
        mk(OP_WR, A_CTRL, 32'h0100000F, 32'd0, 1'b0, 4'd0),
        mk(OP_TM, A_CTRL, 32'd2, 32'd0, 1'b0, 4'd0),
        mk(OP_RD, A_STAT, 32'd0, 32'd1, 1'b1, 4'd7),            // R7 compare hit
        mk(OP_WR, A_STAT, 32'd0, 32'd0, 1'b0, 4'd0),
        mk(OP_RD, A_STAT, 32'd0, 32'd1, 1'b1, 4'd8),            // R8 write 0 no effect
        mk(OP_WR, A_STAT, 32'd1, 32'd0, 1'b0, 4'd0),
        mk(OP_RD, A_STAT, 32'd0, 32'd0, 1'b0, 4'd8),            // R8 write 1 clears
        mk(OP_WR, A_CTRL, 32'h01000003, 32'd0, 1'b0, 4'd0),
        mk(OP_RD, A_CNT,  32'd0, 32'hFFFFFFFF, 1'b0, 4'd5),     // R5 restart free-run
        mk(OP_TM, A_CTRL, 32'd1, 32'd0, 1'b0, 4'd0),
        mk(OP_RD, A_CNT,  32'd0, 32'hFFFFFFFE, 1'b0, 4'd4),
        mk(OP_WR, A_CTRL, 32'h01020001, 32'd0, 1'b0, 4'd0),
        mk(OP_WR, A_LOAD, 32'd1, 32'd0, 1'b0, 4'd0),
        mk(OP_RD, A_CNT,  32'd0, 32'd1, 1'b0, 4'd6),            // R6 overwrite
        mk(OP_TM, A_CTRL, 32'd2, 32'd0, 1'b0, 4'd0),
        mk(OP_RD, A_CNT,  32'd0, 32'hFFFFFFFF, 1'b0, 4'd4),     // R4 wrap to ones
        mk(OP_WR, A_LOAD, 32'd5, 32'd0, 1'b0, 4'd0),
        mk(OP_WR, A_CTRL, 32'h0100002B, 32'd0, 1'b0, 4'd0),
        mk(OP_TM, A_CTRL, 32'd3, 32'd0, 1'b0, 4'd0),
        mk(OP_RD, A_CNT,  32'd0, 32'd4, 1'b0, 4'd3),            // R3 divide by 3
        mk(OP_TM, A_CTRL, 32'd2, 32'd0, 1'b0, 4'd0),
        mk(OP_RD, A_CNT,  32'd0, 32'd4, 1'b0, 4'd3),
        mk(OP_TM, A_CTRL, 32'd1, 32'd0, 1'b0, 4'd0),
        mk(OP_RD, A_CNT,  32'd0, 32'd3, 1'b0, 4'd3),
        mk(OP_WR, A_CTRL, 32'h0000000B, 32'd0, 1'b0, 4'd0),
        mk(OP_TM, A_CTRL, 32'd5, 32'd0, 1'b0, 4'd0),
        mk(OP_RD, A_CNT,  32'd0, 32'd5, 1'b0, 4'd3),            // R3 source none
        mk(OP_WR, A_CTRL, 32'h0300000B, 32'd0, 1'b0, 4'd0),
        mk(OP_TM, A_CTRL, 32'd4, 32'd0, 1'b0, 4'd0),
        mk(OP_RD, A_CNT,  32'd0, 32'd5, 1'b0, 4'd3),            // R3 slow ignores main
        mk(OP_TS, A_CTRL, 32'd2, 32'd0, 1'b0, 4'd0),
        mk(OP_RD, A_CNT,  32'd0, 32'd3, 1'b0, 4'd3),
        mk(OP_WR, A_CTRL, 32'h0200000B, 32'd0, 1'b0, 4'd0),
        mk(OP_TM, A_CTRL, 32'd1, 32'd0, 1'b0, 4'd0),
        mk(OP_RD, A_CNT,  32'd0, 32'd4, 1'b0, 4'd3),            // R3 source 10
        mk(OP_WR, A_CTRL, 32'h0102000B, 32'd0, 1'b0, 4'd0),
        mk(OP_WR, A_LOAD, 32'd9, 32'd0, 1'b0, 4'd0),
        mk(OP_RD, A_CNT,  32'd0, 32'd9, 1'b0, 4'd6),
        mk(OP_WR, A_CTRL, 32'h0100000B, 32'd0, 1'b0, 4'd0),
        mk(OP_WR, A_LOAD, 32'd7, 32'd0, 1'b0, 4'd0),
        mk(OP_RD, A_CNT,  32'd0, 32'd9, 1'b0, 4'd6),            // R6 deferred load
        mk(OP_TM, A_CTRL, 32'd10, 32'd0, 1'b0, 4'd0),
        mk(OP_RD, A_CNT,  32'd0, 32'd7, 1'b0, 4'd6),
        mk(OP_WR, A_CTRL, 32'h0100000A, 32'd0, 1'b0, 4'd0),
        mk(OP_TM, A_CTRL, 32'd3, 32'd0, 1'b0, 4'd0),
        mk(OP_RD, A_CNT,  32'd0, 32'd7, 1'b0, 4'd5),            // R5 halted
        mk(OP_WR, A_CTRL, 32'h01000009, 32'd0, 1'b0, 4'd0),
        mk(OP_TM, A_CTRL, 32'd1, 32'd0, 1'b0, 4'd0),
        mk(OP_RD, A_CNT,  32'd0, 32'd6, 1'b0, 4'd5)             // R5 continue
    };

    task automatic check(input string what, input int req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] ofs, input logic [31:0] val);
        @(negedge clk);
        bus_addr = ofs; bus_wdata = val; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] ofs, input logic [31:0] exp, input logic ex_irq, input int req);
        @(negedge clk);
        bus_addr = ofs;
        #1;
        check($sformatf("read ofs %0d", ofs), req, bus_rdata, exp);
        check("irq", req, {31'd0, irq}, {31'd0, ex_irq});
    endtask

    task automatic pulse(input int n, input bit slow);
        @(negedge clk);
        if (slow) tick_slow = 1'b1; else tick_main = 1'b1;
        repeat (n) @(negedge clk);
        tick_slow = 1'b0; tick_main = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        vec_t v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        rd(A_CTRL, 32'd0, 1'b0, 10);
        rd(A_STAT, 32'd0, 1'b0, 10);
        rd(A_LOAD, 32'hFFFFFFFF, 1'b0, 10);
        rd(A_CMP,  32'd0, 1'b0, 10);
        rd(A_CNT,  32'd0, 1'b0, 10);

        for (int i = 0; i < NV; i++) begin
            v = VECS[i];
            case (v.op)
                OP_WR:   wr(v.ofs, v.val);
                OP_RD:   rd(v.ofs, v.exp, v.exp_irq, int'(v.req));
                OP_TM:   pulse(int'(v.val), 1'b0);
                default: pulse(int'(v.val), 1'b1);
            endcase
        end

        // R7 compare value zero: flag only at expiry
        wr(A_CMP, 32'd0);
        wr(A_CTRL, 32'h0100000F);
        pulse(7, 1'b0);
        rd(A_STAT, 32'd0, 1'b0, 7);
        pulse(1, 1'b0);
        rd(A_STAT, 32'd1, 1'b1, 7);
        rd(A_CNT,  32'd7, 1'b1, 4);
        // R9 gating by run and by compare-interrupt enable
        wr(A_CTRL, 32'h0100000E);
        rd(A_STAT, 32'd1, 1'b0, 9);
        wr(A_CTRL, 32'h01000009);
        rd(A_STAT, 32'd1, 1'b0, 9);
        // R11 soft reset
        wr(A_CTRL, 32'h013F00FF);
        rd(A_CTRL, 32'h010200FC, 1'b0, 11);
        rd(A_STAT, 32'd0, 1'b0, 11);
        rd(A_LOAD, 32'hFFFFFFFF, 1'b0, 11);
        rd(A_CMP,  32'd0, 1'b0, 11);
        rd(A_CNT,  32'd0, 1'b0, 11);
        // R1 reserved offsets and read-only count
        wr(3'd5, 32'h00001234);
        rd(3'd5, 32'd0, 1'b0, 1);
        rd(A_CTRL, 32'h010200FC, 1'b0, 1);
        wr(A_CNT, 32'h55);
        rd(A_CNT, 32'd0, 1'b0, 1);
        // R2 upper bits dropped
        wr(A_CTRL, 32'hFD000000);
        rd(A_CTRL, 32'h01000000, 1'b0, 2);
        // R8 set wins over clear in the same cycle
        wr(A_LOAD, 32'd5);
        wr(A_CMP, 32'd3);
        wr(A_CTRL, 32'h0100000F);
        pulse(1, 1'b0);
        @(negedge clk);
        bus_addr = A_STAT; bus_wdata = 32'd1; bus_wr = 1'b1; tick_main = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; tick_main = 1'b0;
        rd(A_STAT, 32'd1, 1'b1, 8);
        rd(A_CNT,  32'd3, 1'b1, 8);
        // R10 hard reset mid-run
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        rd(A_CTRL, 32'd0, 1'b0, 10);
        rd(A_STAT, 32'd0, 1'b0, 10);
        rd(A_CNT,  32'd0, 1'b0, 10);
        rd(A_LOAD, 32'hFFFFFFFF, 1'b0, 10);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule